// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a serial test port controller clocked by its own test clock. A mode-select line steers a sixteen-state controller through capture, shift, pause and update phases for two branches. One branch loads a 3-bit instruction and the other moves a data register. The active instruction chooses which data register sits between the serial input and the serial output. The choices are a 32-bit identification word, a boundary register that samples a parallel vector of pin states, or a single-bit bypass stage.

The serial input and the mode-select line are sampled on the rising test-clock edge. The serial output and its enable change only on the falling edge, so the far end can sample them on its next rising edge. An asynchronous power-on reset, or five consecutive rising edges with the mode-select line high, returns the controller to its reset state. Either one also makes the identification instruction active. The sample instruction only captures pin states: data shifted into the boundary register never reaches any pin.

Top module: `tap_ctrl`

## Requirements
- R1: While `por_n` is low the controller is held in Test-Logic-Reset, the active instruction is the identification code 3'b001, and `tdo_oe` is 0. The first data-register scan after reset returns the identification word.
- R2: Five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset from any state, and the active instruction becomes 3'b001.
- R3: State changes follow the standard sixteen-state diagram. A data shift suspended through Exit1, Pause and Exit2 resumes with its register contents intact, with no new capture.
- R4: In Capture-IR the instruction shift register loads 3'b001, which shifts out LSB first as 1, 0, 0. In Update-IR the shifted-in value becomes the active instruction.
- R5: Instruction 3'b001 selects the 32-bit identification word. Its fields are: bits 31:29 revision 000, bits 28:24 depth 01011, bits 23:18 architecture 001001, bits 17:12 width/density 100100, bits 11:1 manufacturer 00000110100, and bit 0 equal to 1.
- R6: Instruction 3'b010 selects the boundary register. Capture-DR loads `pin_in`, and `pin_in[0]` comes out first. Bits shifted in drive nothing, and the next capture replaces them.
- R7: Codes 3'b111, 3'b000, 3'b011, 3'b100, 3'b101 and 3'b110 all select the 1-bit bypass stage. It captures 0, so a scan returns 0 followed by the serial input delayed by one bit.
- R8: `tdo_oe` is 1 exactly while the controller is in Shift-DR or Shift-IR, as updated at the falling edge after the state is entered.
- R9: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdi` and `tms` are taken on rising edges. Data registers shift LSB first toward `tdo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pin_in | input | BSR_LEN | Parallel pin states captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | High while tdo carries shift data |

## Verification
A wrong controller state shows up first on `tdo_oe`. That enable rises or falls at the falling edge after a mistaken transition, so a diagram error is visible within one clock. A wrong active instruction or a wrong capture value only shows during a later scan. It appears as the first bit out: 0 for bypass, 1 for the identification word, `pin_in[0]` for the boundary register. A lost pause or a broken shift path shows as a bit-position error within the scan length. The checks therefore compare complete scans as well as single enable samples taken around edges.

// File: rtl/tap_ctrl.sv
module tap_ctrl #(
  parameter int          BSR_LEN   = 8,
  parameter logic [2:0]  ID_REV    = 3'b000,
  parameter logic [4:0]  ID_DEPTH  = 5'b01011,
  parameter logic [5:0]  ID_ARCH   = 6'b001001,
  parameter logic [5:0]  ID_WIDTH  = 6'b100100,
  parameter logic [10:0] ID_MFR    = 11'b00000110100,
  parameter logic [2:0]  OP_IDCODE = 3'b001,
  parameter logic [2:0]  OP_SAMPLE = 3'b010
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               tdo,
  output logic               tdo_oe
);

  localparam logic [31:0] ID_WORD  = {ID_REV, ID_DEPTH, ID_ARCH, ID_WIDTH, ID_MFR, 1'b1};
  localparam logic [2:0]  IR_CAPT  = 3'b001;

  typedef enum logic [3:0] {
    TLR = 4'd0, RTI = 4'd1, SELDR = 4'd2, CAPDR = 4'd3, SHDR = 4'd4,
    EX1DR = 4'd5, PSDR = 4'd6, EX2DR = 4'd7, UPDR = 4'd8, SELIR = 4'd9,
    CAPIR = 4'd10, SHIR = 4'd11, EX1IR = 4'd12, PSIR = 4'd13, EX2IR = 4'd14,
    UPIR = 4'd15
  } tap_st_e;

  tap_st_e state, nxt;
  logic [2:0]         ir, ir_sh;
  logic               byp;
  logic [31:0]        id_sh;
  logic [BSR_LEN-1:0] bsr;

  wire sel_id = (ir == OP_IDCODE);
  wire sel_bs = (ir == OP_SAMPLE);
  wire dr_bit = sel_id ? id_sh[0] : sel_bs ? bsr[0] : byp;

  always_comb begin
    unique case (state)
      TLR:   nxt = tms ? TLR   : RTI;
      RTI:   nxt = tms ? SELDR : RTI;
      SELDR: nxt = tms ? SELIR : CAPDR;
      CAPDR: nxt = tms ? EX1DR : SHDR;
      SHDR:  nxt = tms ? EX1DR : SHDR;
      EX1DR: nxt = tms ? UPDR  : PSDR;
      PSDR:  nxt = tms ? EX2DR : PSDR;
      EX2DR: nxt = tms ? UPDR  : SHDR;
      UPDR:  nxt = tms ? SELDR : RTI;
      SELIR: nxt = tms ? TLR   : CAPIR;
      CAPIR: nxt = tms ? EX1IR : SHIR;
      SHIR:  nxt = tms ? EX1IR : SHIR;
      EX1IR: nxt = tms ? UPIR  : PSIR;
      PSIR:  nxt = tms ? EX2IR : PSIR;
      EX2IR: nxt = tms ? UPIR  : SHIR;
      UPIR:  nxt = tms ? SELDR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= TLR;
    else        state <= nxt;
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir    <= OP_IDCODE;
      ir_sh <= IR_CAPT;
    end else begin
      case (state)
        TLR:   ir    <= OP_IDCODE;
        CAPIR: ir_sh <= IR_CAPT;
        SHIR:  ir_sh <= {tdi, ir_sh[2:1]};
        UPIR:  ir    <= ir_sh;
        default: ;
      endcase
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp   <= 1'b0;
      id_sh <= ID_WORD;
      bsr   <= '0;
    end else if (state == CAPDR) begin
      if (sel_id)      id_sh <= ID_WORD;
      else if (sel_bs) bsr   <= pin_in;
      else             byp   <= 1'b0;
    end else if (state == SHDR) begin
      if (sel_id)      id_sh <= {tdi, id_sh[31:1]};
      else if (sel_bs) bsr   <= {tdi, bsr[BSR_LEN-1:1]};
      else             byp   <= tdi;
    end
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == SHDR) || (state == SHIR);
      if (state == SHIR)      tdo <= ir_sh[0];
      else if (state == SHDR) tdo <= dr_bit;
    end
  end

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk (
  input logic       tck,
  input logic       por_n,
  input logic       tms,
  input logic [3:0] state,
  input logic [2:0] ir,
  input logic [2:0] ir_sh,
  input logic       byp,
  input logic       tdo_oe
);
  localparam logic [3:0] S_TLR = 4'd0, S_CAPDR = 4'd3, S_SHDR = 4'd4,
                         S_CAPIR = 4'd10, S_SHIR = 4'd11, S_UPIR = 4'd15;

  logic [2:0] hi_cnt;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)               hi_cnt <= '0;
    else if (!tms)            hi_cnt <= '0;
    else if (hi_cnt != 3'd5)  hi_cnt <= hi_cnt + 3'd1;
  end

  assert_five_high_R2: assert property (@(posedge tck) disable iff (!por_n)
    (hi_cnt == 3'd5) |-> (state == S_TLR));

  assert_tlr_idcode_R1: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_TLR) |=> (ir == 3'b001));

  assert_capir_pattern_R4: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_CAPIR) |=> (ir_sh == 3'b001));

  assert_upir_load_R4: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_UPIR) |=> (ir == $past(ir_sh)));

  assert_byp_capture_R7: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_CAPDR && ir != 3'b001 && ir != 3'b010) |=> (byp == 1'b0));

  assert_oe_shift_R8: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == (state == S_SHDR || state == S_SHIR));
endmodule

bind tap_ctrl tap_ctrl_chk u_chk (.*);

// File: tb/sim_tap_ctrl.sv
`timescale 1ns/1ps
module sim_tap_ctrl;
  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [7:0] pin_in = '0;
  logic tdo, tdo_oe;
  int n_run = 0, n_fail = 0;

  localparam logic [31:0] ID_EXP = {3'b000, 5'b01011, 6'b001001, 6'b100100, 11'b00000110100, 1'b1};

  // {opcode, pins, shifted-in, expected first 8 bits out}
  localparam logic [26:0] VEC [9] = '{
    {3'b001, 8'hA5, 8'h3C, 8'h69},
    {3'b010, 8'hA5, 8'h00, 8'hA5},
    {3'b010, 8'h5A, 8'hFF, 8'h5A},
    {3'b111, 8'hFF, 8'hB7, 8'h6E},
    {3'b000, 8'h0F, 8'h81, 8'h02},
    {3'b011, 8'h00, 8'h55, 8'hAA},
    {3'b100, 8'h00, 8'hC3, 8'h86},
    {3'b101, 8'h00, 8'h01, 8'h02},
    {3'b110, 8'h00, 8'h40, 8'h80}
  };

  tap_ctrl #(.BSR_LEN(8)) u0 (.tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi),
    .pin_in(pin_in), .tdo(tdo), .tdo_oe(tdo_oe));

  always #4 tck = ~tck;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic scan_ir(input logic [2:0] v, output logic [2:0] got);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      got[i] = tdo;
      step(i == 2, v[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [31:0] din, input int n, output logic [31:0] got);
    got = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      got[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [2:0]  irg;
    logic [31:0] g;
    @(negedge tck); @(negedge tck); #1;
    check("R1 oe in reset", {31'd0, tdo_oe}, 32'd0);
    por_n = 1'b1;
    step(0, 0);
    scan_dr(32'h0, 32, g);
    check("R1/R5 id after reset", g, ID_EXP);

    for (int k = 0; k < 9; k++) begin
      pin_in = VEC[k][23:16];
      scan_ir(VEC[k][26:24], irg);
      check("R4 ir capture", {29'd0, irg}, 32'd1);
      scan_dr({24'd0, VEC[k][15:8]}, 8, g);
      check("R5/R6/R7 dr scan", g, {24'd0, VEC[k][7:0]});
    end

    scan_ir(3'b111, irg);
    step(1, 0); step(0, 0); step(0, 0);
    check("R7 byp first bit", {31'd0, tdo}, 32'd0);
    step(0, 1);
    step(1, 1);
    step(0, 0);
    check("R8 oe in pause", {31'd0, tdo_oe}, 32'd0);
    step(1, 0); step(0, 0);
    check("R3 resume keeps data", {30'd0, tdo_oe, tdo}, 32'd3);
    tms = 0; tdi = 0;
    @(posedge tck); #1;
    check("R9 no change at rise", {31'd0, tdo}, 32'd1);
    @(negedge tck); #1;
    check("R9 change at fall", {31'd0, tdo}, 32'd0);
    step(1, 0); step(1, 0); step(0, 0);

    scan_ir(3'b111, irg);
    step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    check("R2 oe after five", {31'd0, tdo_oe}, 32'd0);
    step(0, 0);
    scan_dr(32'hFFFF_FFFF, 32, g);
    check("R2 idcode after five", g, ID_EXP);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule